// File: doc/BRIEF.md
# Accumulator CPU Core

A small multicycle processor built around a 24-bit accumulator `A`. It also has an index register `X`, a 15-bit link register `L`, a 15-bit program counter and a three-way condition code. Code and data share a byte-wide synchronous memory of 32,768 bytes. Every instruction and every data word is three bytes long, stored most-significant byte first at the lowest address. An instruction word carries an 8-bit opcode in bits [23:16], an index flag in bit [15] and a 15-bit address in bits [14:0]. When the index flag is set, the effective address is the address field plus the low 15 bits of `X`, taken modulo 2^15.

The controller has seven states:
- `ST_FETCH` reads three instruction bytes and adds 3 to the PC.
- `ST_DECODE` computes the effective address. It completes jumps, call, return and device test itself.
- `ST_READ` collects a three-byte operand. `ST_EXEC` then applies a load, an arithmetic operation or a compare.
- `ST_WRITE` emits three store bytes.
- `ST_DEVICE` waits for a device to become ready and transfers one byte.
- `ST_HALT` is entered on an unknown opcode and is left only by reset.

The transitions are:
- FETCH→DECODE after the third byte.
- DECODE→READ for loads, arithmetic and compare.
- DECODE→WRITE for stores.
- DECODE→DEVICE for device read and device write.
- DECODE→FETCH for jumps, call, return and device test.
- DECODE→HALT for any other opcode.
- READ→EXEC, then EXEC→FETCH.
- WRITE→FETCH after the third byte.
- DEVICE→FETCH once the device is ready.

Memory timing: the address is presented in one cycle, and the read data is valid in the following cycle. A write takes effect at the clock edge on which `mem_we` is high.

Device operations name the device with the low 8 bits of the effective address, which is driven on `dev_code`.

Top module: `acc_cpu`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `halted`, `div_err`, `mem_we` and both device strobes are 0, and `mem_addr` is 0. The first instruction is fetched from address 0.
- R2: With index flag bit [15] set, the effective address is the address field plus X. An indexed load from field 0x600 with X=3 returns the word stored at 0x603.
- R3: The load opcodes are 0x00 (A) and 0x04 (X), and they copy a memory word into the register. The store opcodes are 0x0C (A) and 0x10 (X), and they write the register to memory. Words occupy three bytes, most significant byte at the lowest address.
- R4: Opcode 0x18 sets A to A+M and opcode 0x1C sets A to A−M, both modulo 2^24.
- R5: Opcode 0x20 leaves the low 24 bits of A×M in A. Opcode 0x24 leaves the signed quotient A/M in A, truncated toward zero.
- R6: Division by a zero word leaves A unchanged and sets `div_err`. `div_err` stays 1 until reset, and execution continues.
- R7: Opcode 0x28 compares A with M as signed numbers and sets the code to less, equal or greater.
  - 0x38 jumps on less, 0x30 jumps on equal, 0x34 jumps on greater, and 0x3C jumps always.
  - A jump that is not taken falls through to the next instruction.
- R8: Opcode 0x48 saves the address of the next instruction in L and jumps to the effective address. Opcode 0x4C jumps to L.
- R9: Opcode 0xE0 sets the code to less if `dev_ready` is 1 in its decode cycle, and to equal otherwise.
- R10: Opcodes 0xD8 (read) and 0xDC (write) wait until `dev_ready` is 1. They then pulse the matching strobe for exactly one cycle, in which `dev_ready` is 1.
  - A read replaces A[7:0] with `dev_rdata` and keeps A[23:8].
  - A write drives A[7:0] on `dev_wdata`.
- R11: Any other opcode sets `halted`, which then stays 1. No memory write and no strobe occurs after that.
- R12: `mem_we`, `dev_rd_stb` and `dev_wr_stb` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 15 | Byte address to memory |
| mem_we | output | 1 | Byte write enable |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after its address |
| dev_code | output | 8 | Selected device number |
| dev_ready | input | 1 | Selected device can transfer |
| dev_rd_stb | output | 1 | One-cycle pulse: byte taken from the device |
| dev_wr_stb | output | 1 | One-cycle pulse: byte given to the device |
| dev_wdata | output | 8 | Byte to the device (A[7:0]) |
| dev_rdata | input | 8 | Byte from the device |
| halted | output | 1 | Unknown opcode seen; core stopped |
| div_err | output | 1 | Sticky division-by-zero flag |

## Verification
A call does two things at the same clock edge in its decode cycle: it captures the already-advanced PC into L, and it redirects the PC to the target. The subroutine's own return must then land on the store that follows the call. Every random program makes such a call and checks both the subroutine's store and the store after the return. A wrong link value either loops until the run times out or skips the second store.

In each program a compare is followed directly by a chain of three conditional jumps, so the code written in one execute cycle is consumed by the next decode cycle. Operand pairs are drawn so that less, equal and greater all occur, and the stored path marker is checked against the signed order computed by the bench.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [7:0] {
        OP_LDA  = 8'h00,
        OP_LDX  = 8'h04,
        OP_STA  = 8'h0C,
        OP_STX  = 8'h10,
        OP_ADD  = 8'h18,
        OP_SUB  = 8'h1C,
        OP_MUL  = 8'h20,
        OP_DIV  = 8'h24,
        OP_COMP = 8'h28,
        OP_JEQ  = 8'h30,
        OP_JGT  = 8'h34,
        OP_JLT  = 8'h38,
        OP_J    = 8'h3C,
        OP_JSUB = 8'h48,
        OP_RSUB = 8'h4C,
        OP_RD   = 8'hD8,
        OP_WD   = 8'hDC,
        OP_TD   = 8'hE0
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_READ,
        ST_EXEC,
        ST_WRITE,
        ST_DEVICE,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2
    } cc_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_MUL,
        ALU_DIV
    } alu_op_e;

endpackage

// File: rtl/acc_agen.sv
module acc_agen #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] field,
    input  logic              idx,
    input  logic [ADDR_W-1:0] xlow,
    output logic [ADDR_W-1:0] ea
);
    // Effective address wraps inside the address space.
    always_comb begin
        ea = field + (idx ? xlow : '0);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 24
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   y,
    output logic           div_zero,
    output cc_e            cmp
);
    logic [W-1:0] quo;

    always_comb begin
        div_zero = (m == '0);
        quo      = div_zero ? a : W'($signed(a) / $signed(m));
        case (op)
            ALU_ADD: y = a + m;
            ALU_SUB: y = a - m;
            ALU_MUL: y = a * m;
            ALU_DIV: y = quo;
            default: y = a;
        endcase
        if ($signed(a) < $signed(m)) begin
            cmp = CC_LT;
        end else if (a == m) begin
            cmp = CC_EQ;
        end else begin
            cmp = CC_GT;
        end
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 15,
    parameter int OPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        dev_code,
    input  logic              dev_ready,
    output logic              dev_rd_stb,
    output logic              dev_wr_stb,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata,
    output logic              halted,
    output logic              div_err
);
    localparam int NBYTES = WORD_W / 8;
    localparam int CNT_W  = $clog2(NBYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST_RD = CNT_W'(NBYTES);
    localparam logic [CNT_W-1:0] CNT_LAST_WR = CNT_W'(NBYTES - 1);

    state_e             state, state_nx;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  pc, ea_q, lreg, ea_c;
    logic [WORD_W-1:0]  ir, areg, xreg, opnd, stval, alu_y;
    cc_e                cc, alu_cc;
    alu_op_e            alu_op;
    logic               alu_dz, derr_q;
    opcode_e            opc;

    assign opc = opcode_e'(ir[WORD_W-1 -: OPC_W]);

    acc_agen #(.ADDR_W(ADDR_W)) u_agen (
        .field (ir[ADDR_W-1:0]),
        .idx   (ir[ADDR_W]),
        .xlow  (xreg[ADDR_W-1:0]),
        .ea    (ea_c)
    );

    always_comb begin
        case (opc)
            OP_SUB:  alu_op = ALU_SUB;
            OP_MUL:  alu_op = ALU_MUL;
            OP_DIV:  alu_op = ALU_DIV;
            default: alu_op = ALU_ADD;
        endcase
    end

    acc_alu #(.W(WORD_W)) u_alu (
        .op       (alu_op),
        .a        (areg),
        .m        (opnd),
        .y        (alu_y),
        .div_zero (alu_dz),
        .cmp      (alu_cc)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  if (cnt == CNT_LAST_RD) state_nx = ST_DECODE;
            ST_DECODE: begin
                case (opc)
                    OP_LDA, OP_LDX, OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_COMP:
                        state_nx = ST_READ;
                    OP_STA, OP_STX:
                        state_nx = ST_WRITE;
                    OP_J, OP_JEQ, OP_JGT, OP_JLT, OP_JSUB, OP_RSUB, OP_TD:
                        state_nx = ST_FETCH;
                    OP_RD, OP_WD:
                        state_nx = ST_DEVICE;
                    default:
                        state_nx = ST_HALT;
                endcase
            end
            ST_READ:   if (cnt == CNT_LAST_RD) state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_FETCH;
            ST_WRITE:  if (cnt == CNT_LAST_WR) state_nx = ST_FETCH;
            ST_DEVICE: if (dev_ready) state_nx = ST_FETCH;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_HALT;
        endcase
    end

    // State register and byte counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) begin
                cnt <= '0;
            end else if (state == ST_FETCH || state == ST_READ || state == ST_WRITE) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            ea_q   <= '0;
            lreg   <= '0;
            ir     <= '0;
            areg   <= '0;
            xreg   <= '0;
            opnd   <= '0;
            cc     <= CC_EQ;
            derr_q <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    if (cnt != '0) ir <= {ir[WORD_W-9:0], mem_rdata};
                    if (cnt == CNT_LAST_RD) pc <= pc + ADDR_W'(NBYTES);
                end
                ST_DECODE: begin
                    ea_q <= ea_c;
                    case (opc)
                        OP_J:    pc <= ea_c;
                        OP_JEQ:  if (cc == CC_EQ) pc <= ea_c;
                        OP_JGT:  if (cc == CC_GT) pc <= ea_c;
                        OP_JLT:  if (cc == CC_LT) pc <= ea_c;
                        OP_JSUB: begin
                            lreg <= pc;
                            pc   <= ea_c;
                        end
                        OP_RSUB: pc <= lreg;
                        OP_TD:   cc <= dev_ready ? CC_LT : CC_EQ;
                        default: ;
                    endcase
                end
                ST_READ: begin
                    if (cnt != '0) opnd <= {opnd[WORD_W-9:0], mem_rdata};
                end
                ST_EXEC: begin
                    case (opc)
                        OP_LDA:  areg <= opnd;
                        OP_LDX:  xreg <= opnd;
                        OP_ADD, OP_SUB, OP_MUL: areg <= alu_y;
                        OP_DIV: begin
                            if (alu_dz) derr_q <= 1'b1;
                            else        areg   <= alu_y;
                        end
                        OP_COMP: cc <= alu_cc;
                        default: ;
                    endcase
                end
                ST_DEVICE: begin
                    if (dev_ready && opc == OP_RD) areg[7:0] <= dev_rdata;
                end
                ST_WRITE, ST_HALT: ;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        stval      = (opc == OP_STX) ? xreg : areg;
        mem_addr   = pc;
        mem_we     = 1'b0;
        mem_wdata  = stval[8*(NBYTES-1-int'(cnt)) +: 8];
        dev_rd_stb = 1'b0;
        dev_wr_stb = 1'b0;
        unique case (state)
            ST_FETCH:  mem_addr = pc + ADDR_W'(cnt);
            ST_READ:   mem_addr = ea_q + ADDR_W'(cnt);
            ST_WRITE: begin
                mem_addr = ea_q + ADDR_W'(cnt);
                mem_we   = 1'b1;
            end
            ST_DEVICE: begin
                dev_rd_stb = dev_ready && (opc == OP_RD);
                dev_wr_stb = dev_ready && (opc == OP_WD);
            end
            ST_DECODE, ST_EXEC, ST_HALT: ;
            default: ;
        endcase
    end

    assign dev_code  = ea_c[7:0];
    assign dev_wdata = areg[7:0];
    assign halted    = (state == ST_HALT);
    assign div_err   = derr_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_we,
    input logic dev_rd_stb,
    input logic dev_wr_stb,
    input logic dev_ready,
    input logic halted,
    input logic div_err
);
    p_io_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, dev_rd_stb, dev_wr_stb}));

    p_stb_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd_stb || dev_wr_stb) |-> dev_ready);

    p_stb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd_stb || dev_wr_stb) |=> !(dev_rd_stb || dev_wr_stb));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_we || dev_rd_stb || dev_wr_stb));

    p_derr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |=> div_err);
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we     (mem_we),
    .dev_rd_stb (dev_rd_stb),
    .dev_wr_stb (dev_wr_stb),
    .dev_ready  (dev_ready),
    .halted     (halted),
    .div_err    (div_err)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    localparam int CLK_NS = 20;
    localparam int DA = 'h600, DB = 'h603, XV = 'h606, K1 = 'h609, K2 = 'h60C, K3 = 'h60F, DW = 'h612;
    localparam int RB = 'h700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  dev_code, dev_wdata;
    logic        dev_ready, dev_rd_stb, dev_wr_stb;
    logic [7:0]  dev_rdata = 8'hA5;
    logic        halted, div_err;

    logic [7:0]  mem [0:2047];
    int          total = 0, bad = 0, excl_bad = 0;
    int          ppos;
    int          wait_cnt = 0, wd_cnt = 0, rd_cnt = 0;
    logic [7:0]  wd_byte, wd_code;
    bit          finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    acc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_code(dev_code),
        .dev_ready(dev_ready), .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .halted(halted), .div_err(div_err)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[10:0]];
    end

    // Device 5 never ready, 6 always ready, 7 ready after four waiting cycles.
    assign dev_ready = (dev_code == 8'h06) || (dev_code == 8'h07 && wait_cnt >= 4);

    always @(posedge clk) begin
        if (dev_rd_stb || dev_wr_stb) wait_cnt <= 0;
        else if (dev_code == 8'h07 && wait_cnt < 100) wait_cnt <= wait_cnt + 1;
        if (dev_wr_stb) begin
            wd_cnt  <= wd_cnt + 1;
            wd_byte <= dev_wdata;
            wd_code <= dev_code;
        end
        if (dev_rd_stb) rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) begin
        if (rst_n && (int'(mem_we) + int'(dev_rd_stb) + int'(dev_wr_stb)) > 1) excl_bad++;
    end

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic emit(input logic [7:0] op, input bit x, input int addr);
        mem[ppos]     = op;
        mem[ppos + 1] = {x, 7'(addr >> 8)};
        mem[ppos + 2] = 8'(addr);
        ppos += 3;
    endtask

    task automatic put_word(input int addr, input logic [23:0] v);
        mem[addr] = v[23:16]; mem[addr + 1] = v[15:8]; mem[addr + 2] = v[7:0];
    endtask

    function automatic logic [23:0] get_word(input int addr);
        return {mem[addr], mem[addr + 1], mem[addr + 2]};
    endfunction

    function automatic int sx(input logic [23:0] v);
        return int'({{8{v[23]}}, v});
    endfunction

    task automatic clear_all();
        rst_n = 1'b0;
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        ppos = 0;
    endtask

    task automatic run_prog(input bit check_reset);
        repeat (3) @(negedge clk);
        if (check_reset) begin
            chk("R1 halted in reset", {23'd0, halted}, 24'd0);
            chk("R1 div_err in reset", {23'd0, div_err}, 24'd0);
            chk("R1 mem_we in reset", {23'd0, mem_we}, 24'd0);
            chk("R1 strobes in reset", {22'd0, dev_rd_stb, dev_wr_stb}, 24'd0);
        end
        rst_n = 1'b1;
        if (check_reset) begin
            chk("R1 first fetch address", {9'd0, mem_addr}, 24'd0);
        end
        for (int c = 0; c < 6000 && !halted; c++) @(negedge clk);
        chk("R11 program reached halt", {23'd0, halted}, 24'd1);
        repeat (4) @(negedge clk);
        chk("R11 halted stays set", {23'd0, halted}, 24'd1);
    endtask

    task automatic main_prog(input logic [23:0] a, input logic [23:0] b, input bit check_reset);
        int p, s;
        logic [23:0] e_div, e_cmp;
        clear_all();
        put_word(DA, a); put_word(DB, b); put_word(XV, 24'd3);
        put_word(K1, 24'd1); put_word(K2, 24'd2); put_word(K3, 24'd3);
        emit(8'h04, 0, XV);
        emit(8'h00, 0, DA); emit(8'h18, 0, DB); emit(8'h0C, 0, RB);
        emit(8'h00, 0, DA); emit(8'h1C, 0, DB); emit(8'h0C, 0, RB + 3);
        emit(8'h00, 0, DA); emit(8'h20, 0, DB); emit(8'h0C, 0, RB + 6);
        emit(8'h00, 0, DA); emit(8'h24, 0, DB); emit(8'h0C, 0, RB + 9);
        emit(8'h00, 1, DA); emit(8'h0C, 0, RB + 12);
        emit(8'h10, 0, RB + 15);
        emit(8'h00, 0, DA); emit(8'h28, 0, DB);
        p = ppos;
        emit(8'h38, 0, p + 9); emit(8'h30, 0, p + 18); emit(8'h34, 0, p + 27);
        emit(8'h00, 0, K1); emit(8'h0C, 0, RB + 18); emit(8'h3C, 0, p + 36);
        emit(8'h00, 0, K2); emit(8'h0C, 0, RB + 18); emit(8'h3C, 0, p + 36);
        emit(8'h00, 0, K3); emit(8'h0C, 0, RB + 18); emit(8'h3C, 0, p + 36);
        s = p + 48;
        emit(8'h48, 0, s); emit(8'h0C, 0, RB + 24); emit(8'hFF, 0, 0); emit(8'h0C, 0, RB + 27);
        emit(8'h00, 0, K2); emit(8'h0C, 0, RB + 21); emit(8'h4C, 0, 0);
        run_prog(check_reset);
        e_div = (b == 24'd0) ? a : 24'(sx(a) / sx(b));
        e_cmp = (sx(a) < sx(b)) ? 24'd1 : ((a == b) ? 24'd2 : 24'd3);
        chk("R4 add", get_word(RB), 24'(a + b));
        chk("R4 sub", get_word(RB + 3), 24'(a - b));
        chk("R5 mul low bits", get_word(RB + 6), 24'(a * b));
        chk((b == 0) ? "R6 div by zero keeps A" : "R5 signed div", get_word(RB + 9), e_div);
        chk("R6 div_err flag", {23'd0, div_err}, {23'd0, b == 24'd0});
        chk("R2 indexed load", get_word(RB + 12), b);
        chk("R3 store X", get_word(RB + 15), 24'd3);
        chk("R7 compare and branch path", get_word(RB + 18), e_cmp);
        chk("R8 subroutine body", get_word(RB + 21), 24'd2);
        chk("R8 return to next instruction", get_word(RB + 24), 24'd2);
        chk("R11 nothing after halt", get_word(RB + 27), 24'd0);
    endtask

    task automatic dev_prog();
        clear_all();
        put_word(K1, 24'd1); put_word(DW, 24'h123456);
        emit(8'hE0, 0, 5);  emit(8'h38, 0, 30);
        emit(8'hE0, 0, 6);  emit(8'h30, 0, 30); emit(8'h34, 0, 30);
        emit(8'h00, 0, DW); emit(8'hDC, 0, 7);  emit(8'hD8, 0, 7);
        emit(8'h0C, 0, RB); emit(8'hFF, 0, 0);
        emit(8'h00, 0, K1); emit(8'h0C, 0, RB + 3); emit(8'hFF, 0, 0);
        wd_cnt = 0; rd_cnt = 0;
        run_prog(0);
        chk("R9 test-device codes", get_word(RB + 3), 24'd0);
        chk("R10 read keeps upper A bits", get_word(RB), 24'h1234A5);
        chk("R10 write byte", {16'd0, wd_byte}, 24'h56);
        chk("R10 write device code", {16'd0, wd_code}, 24'h07);
        chk("R10 one write strobe", 24'(wd_cnt), 24'd1);
        chk("R10 one read strobe", 24'(rd_cnt), 24'd1);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] a, b;
        void'($urandom(32'd4242));
        main_prog(24'd5, 24'd5, 1);                 // equal path
        main_prog(24'h800000, 24'd1, 0);            // most negative value
        main_prog(24'd77, 24'd0, 0);                // R6 zero divisor
        main_prog(24'hFFFFF9, 24'd2, 0);            // -7 / 2 truncates to -3
        main_prog(24'd3, 24'hFFFFFF, 0);            // 3 > -1 signed
        for (int it = 0; it < 14; it++) begin
            case ($urandom % 3)
                0: begin a = 24'($urandom); b = 24'($urandom); end
                1: begin a = 24'(int'($urandom % 201) - 100); b = 24'(int'($urandom % 201) - 100); end
                default: begin a = 24'($urandom); b = a; end
            endcase
            if (a == 24'h800000 && b == 24'hFFFFFF) b = 24'd1;
            main_prog(a, b, 0);
        end
        dev_prog();
        chk("R12 exclusive memory write and strobes", 24'(excl_bad), 24'd0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule